// File: doc/BRIEF.md
# Time-Triggered CAN Timebase

This block is the timebase that a CAN controller uses when it runs in time-triggered mode. A programmable prescaler divides the system clock. Each divided tick advances a 16-bit cycle-time counter. When that counter reaches a programmed compare value, it restarts from zero and a 6-bit cycle counter steps forward. Four small registers are reached through a plain read/write port: control, compare value, cycle time and cycle count.

The block drives two timestamp words for the mailbox logic:

- Mailboxes 0 to 15 take `ts_main`. Depending on a control bit, this is either the raw cycle time or the cycle count joined to the upper ten bits of the cycle time. The second form lets software see which basic cycle a reception fell into.
- Mailboxes 30 and 31 take `ts_fixed`, which always carries the raw cycle time.

The compare match can also flush the transmit queue. When it is enabled and the controller is not halted, the block raises a one-clock cancel request for every mailbox that has a transmission pending at the match.

Top module: `ttcan_timebase`

## Requirements
- R1: After reset, the control register (address 0), the cycle time (address 2), the cycle count (address 3) and `tx_cancel` all read zero.
- R2: Control bits 11 to 6 are reserved. They always read zero, and a write to them changes no behaviour. Writing 0xFFFF to address 0 reads back 0xF03F.
- R3: Bit 15 is the run bit. When it is written to 0, the cycle time and cycle count are cleared on the following clock and stay at zero while it remains 0.
- R4: Bits 5 to 0 hold a prescale value P. While the timer runs, the cycle time advances once every P+1 clocks, starting P+1 clocks after the run bit takes effect.
- R5: Bit 12 enables the compare. With bit 12 set, a tick that finds the cycle time equal to the compare value (address 1) sets the cycle time to zero and adds one to the cycle count. With bit 12 clear, the cycle time passes the compare value and wraps only at 0xFFFF, and the cycle count stays unchanged.
- R6: The cycle count wraps from 63 to 0.
- R7: Bit 14 selects the format of `ts_main`. When bit 14 is 0, `ts_main` equals the cycle time. When bit 14 is 1, `ts_main` is {cycle count[5:0], cycle time[15:6]}.
- R8: `ts_fixed` equals the cycle time whatever bit 14 holds.
- R9: When bits 13 and 12 are both set and a compare match occurs, `tx_cancel` equals `tx_pending` as sampled in the match cycle, for exactly the one clock that follows the match. At all other times it is zero.
- R10: If `halt_i` is high in the match cycle, no cancel request is raised. The cycle count still advances.
- R11: If bit 13 is clear, or bit 12 is clear, a match produces no cancel request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 2 | Register select: 0 control, 1 compare, 2 cycle time, 3 cycle count |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| halt_i | input | 1 | Controller halted; blocks cancellation |
| tx_pending | input | 32 | One bit per mailbox with a transmission pending |
| tx_cancel | output | 32 | One-clock cancel request per mailbox |
| ts_main | output | 16 | Timestamp for mailboxes 0 to 15 |
| ts_fixed | output | 16 | Timestamp for mailboxes 30 and 31 |

## Verification
In the same clock edge, a compare match restarts the cycle time, steps the cycle count and decides the cancel pulse. The halt input and changes to the pending vector can land on that same edge.

The bench puts the match at a known edge, four ticks after start with compare 3. It holds `halt_i` high or low for the first and the second match separately, and it swaps the pending vector between the two matches. At each edge it checks that the pulse carries the vector that was present at that match, and that a blocked cancel still leaves the cycle count advancing.

// File: rtl/ttcan_timebase_pkg.sv
package ttcan_timebase_pkg;

    localparam int REG_W   = 16;
    localparam int PSC_W   = 6;
    localparam int ADDR_W  = 2;

    localparam int BIT_RUN    = 15;
    localparam int BIT_TSCAT  = 14;
    localparam int BIT_CXL    = 13;
    localparam int BIT_CMPEN  = 12;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CTRL  = 2'd0,
        ADDR_CMP   = 2'd1,
        ADDR_TIME  = 2'd2,
        ADDR_CYCLE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic             run;
        logic             ts_cat;
        logic             cancel_en;
        logic             cmp_en;
        logic [PSC_W-1:0] psc;
    } ctrl_t;

endpackage

// File: rtl/ttcan_ctrl_regs.sv
module ttcan_ctrl_regs
    import ttcan_timebase_pkg::*;
#(
    parameter int TIME_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output ctrl_t             ctrl,
    output logic [TIME_W-1:0] cmp_val
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [TIME_W-1:0] cmp;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            if (wr_addr == ADDR_CTRL) begin
                regs_d.ctrl.run       = wr_data[BIT_RUN];
                regs_d.ctrl.ts_cat    = wr_data[BIT_TSCAT];
                regs_d.ctrl.cancel_en = wr_data[BIT_CXL];
                regs_d.ctrl.cmp_en    = wr_data[BIT_CMPEN];
                regs_d.ctrl.psc       = wr_data[PSC_W-1:0];
            end else if (wr_addr == ADDR_CMP) begin
                regs_d.cmp = wr_data[TIME_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign ctrl    = regs_q.ctrl;
    assign cmp_val = regs_q.cmp;

endmodule

// File: rtl/ttcan_prescaler.sv
module ttcan_prescaler
    import ttcan_timebase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    typedef struct packed {
        logic [PSC_W-1:0] div;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic       at_limit;

    assign at_limit = (st_q.div == psc);

    always_comb begin
        st_d = st_q;
        if (!run)          st_d.div = '0;
        else if (at_limit) st_d.div = '0;
        else               st_d.div = st_q.div + PSC_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = run && at_limit;

endmodule

// File: rtl/ttcan_cycle_timer.sv
module ttcan_cycle_timer #(
    parameter int TIME_W = 16,
    parameter int CYC_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              cmp_en,
    input  logic [TIME_W-1:0] cmp_val,
    output logic [TIME_W-1:0] cyc_time,
    output logic [CYC_W-1:0]  cyc_cnt,
    output logic              match
);

    typedef struct packed {
        logic [TIME_W-1:0] time_v;
        logic [CYC_W-1:0]  cycle;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    assign match = run && tick && cmp_en && (st_q.time_v == cmp_val);

    always_comb begin
        st_d = st_q;
        if (!run) begin
            st_d = '0;
        end else if (match) begin
            st_d.time_v = '0;
            st_d.cycle  = st_q.cycle + CYC_W'(1);
        end else if (tick) begin
            st_d.time_v = st_q.time_v + TIME_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cyc_time = st_q.time_v;
    assign cyc_cnt  = st_q.cycle;

endmodule

// File: rtl/ttcan_cancel_unit.sv
module ttcan_cancel_unit #(
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              match,
    input  logic              cancel_en,
    input  logic              halt,
    input  logic [NUM_MB-1:0] pending,
    output logic [NUM_MB-1:0] cancel
);

    typedef struct packed {
        logic [NUM_MB-1:0] req;
    } cxl_state_t;

    cxl_state_t st_d, st_q;
    logic       fire;

    assign fire = match && cancel_en && !halt;

    always_comb begin
        st_d = '0;
        for (int i = 0; i < NUM_MB; i++) begin
            st_d.req[i] = fire && pending[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cancel = st_q.req;

endmodule

// File: rtl/ttcan_timebase.sv
module ttcan_timebase
    import ttcan_timebase_pkg::*;
#(
    parameter int TIME_W = 16,
    parameter int CYC_W  = 6,
    parameter int NUM_MB = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic              halt_i,
    input  logic [NUM_MB-1:0] tx_pending,
    output logic [NUM_MB-1:0] tx_cancel,
    output logic [TIME_W-1:0] ts_main,
    output logic [TIME_W-1:0] ts_fixed
);

    localparam int RSV_W = REG_W - 4 - PSC_W;

    ctrl_t             ctrl_q;
    logic [TIME_W-1:0] cmp_val;
    logic              tick;
    logic              match;
    logic [TIME_W-1:0] cyc_time;
    logic [CYC_W-1:0]  cyc_cnt;
    logic [REG_W-1:0]  ctrl_word;

    ttcan_ctrl_regs #(.TIME_W(TIME_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .ctrl    (ctrl_q),
        .cmp_val (cmp_val)
    );

    ttcan_prescaler u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .psc   (ctrl_q.psc),
        .tick  (tick)
    );

    ttcan_cycle_timer #(.TIME_W(TIME_W), .CYC_W(CYC_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (ctrl_q.run),
        .tick     (tick),
        .cmp_en   (ctrl_q.cmp_en),
        .cmp_val  (cmp_val),
        .cyc_time (cyc_time),
        .cyc_cnt  (cyc_cnt),
        .match    (match)
    );

    ttcan_cancel_unit #(.NUM_MB(NUM_MB)) u_cxl (
        .clk       (clk),
        .rst_n     (rst_n),
        .match     (match),
        .cancel_en (ctrl_q.cancel_en),
        .halt      (halt_i),
        .pending   (tx_pending),
        .cancel    (tx_cancel)
    );

    assign ctrl_word = {ctrl_q.run, ctrl_q.ts_cat, ctrl_q.cancel_en,
                        ctrl_q.cmp_en, {RSV_W{1'b0}}, ctrl_q.psc};

    always_comb begin
        unique case (reg_addr)
            ADDR_CTRL:  reg_rdata = ctrl_word;
            ADDR_CMP:   reg_rdata = REG_W'(cmp_val);
            ADDR_TIME:  reg_rdata = REG_W'(cyc_time);
            default:    reg_rdata = REG_W'(cyc_cnt);
        endcase
    end

    generate
        if (TIME_W > CYC_W) begin : g_ts_cat
            assign ts_main = ctrl_q.ts_cat ? {cyc_cnt, cyc_time[TIME_W-1:CYC_W]}
                                           : cyc_time;
        end else begin : g_ts_plain
            assign ts_main = cyc_time;
        end
    endgenerate

    assign ts_fixed = cyc_time;

endmodule

// File: rtl/ttcan_timebase_chk.sv
module ttcan_timebase_chk #(
    parameter int TIME_W = 16,
    parameter int CYC_W  = 6,
    parameter int NUM_MB = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              cancel_en,
    input logic              cmp_en,
    input logic              halt_i,
    input logic [TIME_W-1:0] cyc_time,
    input logic [CYC_W-1:0]  cyc_cnt,
    input logic [NUM_MB-1:0] tx_pending,
    input logic [NUM_MB-1:0] tx_cancel
);

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (cyc_time == '0 && cyc_cnt == '0)); // R3

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(run) |-> (cyc_time == $past(cyc_time) ||
                        cyc_time == $past(cyc_time) + TIME_W'(1) ||
                        cyc_time == '0)); // R4

    AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_cnt == $past(cyc_cnt) || cyc_cnt == $past(cyc_cnt) + CYC_W'(1) ||
         cyc_cnt == '0)); // R6

    AST_CYCLE_NEEDS_CMP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && cyc_cnt != $past(cyc_cnt)) |-> $past(cmp_en)); // R5

    AST_CANCEL_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cancel & ~$past(tx_pending)) == '0); // R9

    AST_CANCEL_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cancel != '0) |-> !$past(halt_i)); // R10

    AST_CANCEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_cancel != '0) |-> $past(cancel_en && cmp_en)); // R11

endmodule

bind ttcan_timebase ttcan_timebase_chk #(
    .TIME_W (TIME_W),
    .CYC_W  (CYC_W),
    .NUM_MB (NUM_MB)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (ctrl_q.run),
    .cancel_en  (ctrl_q.cancel_en),
    .cmp_en     (ctrl_q.cmp_en),
    .halt_i     (halt_i),
    .cyc_time   (cyc_time),
    .cyc_cnt    (cyc_cnt),
    .tx_pending (tx_pending),
    .tx_cancel  (tx_cancel)
);

// File: tb/ttcan_timebase_tb_top.sv
`timescale 1ns/1ps
module ttcan_timebase_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        halt_i = 1'b0;
    logic [31:0] tx_pending = 32'd0;
    logic [31:0] tx_cancel;
    logic [15:0] ts_main;
    logic [15:0] ts_fixed;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ttcan_timebase dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .halt_i     (halt_i),
        .tx_pending (tx_pending),
        .tx_cancel  (tx_cancel),
        .ts_main    (ts_main),
        .ts_fixed   (ts_fixed)
    );

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] cmp;
        logic [31:0] n;
        logic [15:0] exp_time;
        logic [15:0] exp_cyc;
        logic [15:0] exp_ts;
    } vec_t;

    // time = ticks mod (cmp+1) when bit 12 set, cycle = ticks/(cmp+1) mod 64
    localparam vec_t VECS [9] = '{
        '{16'h8000, 16'd5,   32'd10,  16'd10,  16'd0, 16'h000A},
        '{16'h9000, 16'd3,   32'd10,  16'd2,   16'd2, 16'h0002},
        '{16'h8003, 16'd5,   32'd10,  16'd2,   16'd0, 16'h0002},
        '{16'h9002, 16'd1,   32'd20,  16'd0,   16'd3, 16'h0000},
        '{16'h9000, 16'd0,   32'd70,  16'd0,   16'd6, 16'h0000},
        '{16'h9000, 16'd1,   32'd130, 16'd0,   16'd1, 16'h0000},
        '{16'hD000, 16'd3,   32'd10,  16'd2,   16'd2, 16'h0800},
        '{16'hC000, 16'd5,   32'd200, 16'd200, 16'd0, 16'h0003},
        '{16'hD000, 16'd255, 32'd300, 16'd44,  16'd1, 16'h0400}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic start(input logic [15:0] ctrl, input logic [15:0] cmp);
        wr(2'd0, 16'h0000);
        wr(2'd1, cmp);
        wr(2'd0, ctrl);
    endtask

    task automatic cancel_seq(input logic [15:0] ctrl, input logic h1, input logic h2,
                              input logic allowed, input string tag);
        logic [31:0] p1, p2, exp;
        logic [15:0] v;
        p1 = 32'h8000_00F1;
        p2 = 32'h4000_0A02;
        tx_pending = p1;
        halt_i = h1;
        start(ctrl, 16'd3);
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            exp = 32'd0;
            if (k == 4 && allowed && !h1) exp = p1;
            if (k == 8 && allowed && !h2) exp = p2;
            check(tag, tx_cancel, exp);
            if (k == 4) begin
                tx_pending = p2;
                halt_i = h2;
            end
        end
        if (ctrl[12]) begin
            rd(2'd3, v);
            check({tag, " R10 cycle still advances"}, {16'd0, v}, 32'd2);
        end
        halt_i = 1'b0;
        tx_pending = 32'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", {16'd0, v}, 32'd0);
        rd(2'd2, v); check("R1 time", {16'd0, v}, 32'd0);
        rd(2'd3, v); check("R1 cycle", {16'd0, v}, 32'd0);
        check("R1 cancel", tx_cancel, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        rd(2'd2, v); check("R1 time after release", {16'd0, v}, 32'd0);

        // vector table: R4 R5 R6 R7 R8
        foreach (VECS[i]) begin
            start(VECS[i].ctrl, VECS[i].cmp);
            repeat (VECS[i].n) @(negedge clk);
            rd(2'd2, v); check($sformatf("R4/R5 time vec%0d", i), {16'd0, v}, {16'd0, VECS[i].exp_time});
            rd(2'd3, v); check($sformatf("R5/R6 cycle vec%0d", i), {16'd0, v}, {16'd0, VECS[i].exp_cyc});
            check($sformatf("R7 ts_main vec%0d", i), {16'd0, ts_main}, {16'd0, VECS[i].exp_ts});
            check($sformatf("R8 ts_fixed vec%0d", i), {16'd0, ts_fixed}, {16'd0, VECS[i].exp_time});
        end

        // R2 reserved bits
        wr(2'd0, 16'hFFFF);
        rd(2'd0, v); check("R2 readback", {16'd0, v}, 32'h0000_F03F);
        wr(2'd0, 16'h0000);
        wr(2'd0, 16'h0FC0);
        rd(2'd0, v); check("R2 reserved only", {16'd0, v}, 32'd0);
        repeat (4) @(negedge clk);
        rd(2'd2, v); check("R2 no run from reserved", {16'd0, v}, 32'd0);

        // R3 stop clears
        start(16'h9000, 16'd2);
        repeat (7) @(negedge clk);
        rd(2'd3, v); check("R3 running cycle", {16'd0, v}, 32'd2);
        wr(2'd0, 16'h0000);
        @(negedge clk);
        rd(2'd2, v); check("R3 time cleared", {16'd0, v}, 32'd0);
        rd(2'd3, v); check("R3 cycle cleared", {16'd0, v}, 32'd0);
        repeat (5) @(negedge clk);
        rd(2'd2, v); check("R3 time held", {16'd0, v}, 32'd0);

        // cancel behaviour
        cancel_seq(16'hB000, 1'b0, 1'b0, 1'b1, "R9 cancel pulse");
        cancel_seq(16'hB000, 1'b1, 1'b1, 1'b1, "R10 halted");
        cancel_seq(16'hB000, 1'b1, 1'b0, 1'b1, "R10 halt first match only");
        cancel_seq(16'h9000, 1'b0, 1'b0, 1'b0, "R11 cancel bit clear");
        cancel_seq(16'hA000, 1'b0, 1'b0, 1'b0, "R11 compare bit clear");

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule